// File: doc/BRIEF.md
# Idle-Aware Transactional Clock Gate Controller

This block decides, cycle by cycle, whether each of four transactional clock domains receives its clock. Software owns one hint bit per domain. A hint of 1 turns the domain's clock on at once. A hint of 0 is only a request to stop. The clock is gated only when the domain's own hardware reports that it is idle. Until then the controller keeps the clock running and samples the idle signal again on every cycle.

A global low-power request overrides every hint and gates all four clocks. A registered status vector mirrors the real enable state of each domain. Software reads it to learn whether a stop request has actually taken effect.

The gating cells and the bus decoding sit outside this block. The block sees a simple hint write port (a write strobe with data), one idle line per domain and the low-power request. It drives one enable per domain and the status vector.

Top module: `txn_clk_gate_ctrl`

## Requirements
- R1: After reset the hint register holds 4'hF, and both `clk_en` and `en_status` read 4'hF.
- R2: Bit i of `hint_wdata` is the hint for domain i, and domain i drives bit i of `clk_en`, `en_status` and `dom_idle`, for i from 0 to 3.
- R3: Domain i is enabled from the cycle after any clock edge at which `hint_we` is 1, `hint_wdata[i]` is 1 and `low_power` is 0. There is no wait on idle.
- R4: When domain i's hint is 0 and `dom_idle[i]` is 0 at an edge, an enabled clock stays on. The clock is gated at the first edge at which the hint is 0 and `dom_idle[i]` is 1.
- R5: At any edge at which `low_power` is 1, all four enables go to 0, whatever the hints hold and whatever is written at that edge.
- R6: A domain that has been gated with a hint of 0 stays gated, even if its idle line falls again. It turns on again only when a 1 is written to its hint.
- R7: At the first edge after `low_power` returns to 0, every domain whose hint is 1 is enabled again. Domains whose hint is 0 stay gated.
- R8: `en_status` is a registered copy of the enable state. It equals `clk_en` in every cycle.
- R9: When `hint_we` is 0, the value on `hint_wdata` has no effect on the hint register or on the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hint_we | input | 1 | Hint register write strobe |
| hint_wdata | input | 4 | Hint write data, one bit per domain |
| dom_idle | input | 4 | Per-domain idle indication, 1 = idle |
| low_power | input | 1 | Global low-power request, gates all domains |
| clk_en | output | 4 | Per-domain clock enable to the gating cells |
| en_status | output | 4 | Registered readback of the actual enable state |

## Verification
The assertions assume that `hint_we`, `hint_wdata`, `dom_idle` and `low_power` are synchronous to `clk` and stable around the rising edge. They also assume that these inputs carry known values once reset is released. The bench changes every input only on the falling edge. It draws values from $urandom only after reset has been released. This keeps each sampled value clean at the edge that consumes it. The random stream biases `low_power` toward 0 and writes hints less often than it changes idle lines. As a result, busy-wait periods, late idle arrivals and idle drops after gating all occur many times.

// File: rtl/txn_clk_gate_ctrl.sv
module txn_clk_gate_ctrl #(
  parameter int NUM_DOM = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hint_we,
  input  logic [NUM_DOM-1:0] hint_wdata,
  input  logic [NUM_DOM-1:0] dom_idle,
  input  logic               low_power,
  output logic [NUM_DOM-1:0] clk_en,
  output logic [NUM_DOM-1:0] en_status
);

  localparam logic [NUM_DOM-1:0] ALL_ON = {NUM_DOM{1'b1}};

  logic [NUM_DOM-1:0] hint_q;
  logic [NUM_DOM-1:0] hint_eff;
  logic [NUM_DOM-1:0] en_q;
  logic [NUM_DOM-1:0] en_d;
  logic [NUM_DOM-1:0] stat_q;

  assign hint_eff = hint_we ? hint_wdata : hint_q;

  // Enable on hint, hold while busy, drop on idle; low power wins.
  assign en_d = low_power ? '0 : (hint_eff | (en_q & ~dom_idle));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hint_q <= ALL_ON;
      en_q   <= ALL_ON;
      stat_q <= ALL_ON;
    end else begin
      hint_q <= hint_eff;
      en_q   <= en_d;
      stat_q <= en_d;
    end
  end

  assign clk_en    = en_q;
  assign en_status = stat_q;

  // R5
  low_power_gates_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |=> (clk_en == '0));

  // R8
  status_tracks_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_status == clk_en);

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom_chk
    // R3
    enable_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_power && hint_we && hint_wdata[i]) |=> clk_en[i]);

    // R4
    busy_holds_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_power && clk_en[i] && !dom_idle[i]) |=> clk_en[i]);

    // R6
    gated_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en[i] && !hint_q[i] && !(hint_we && hint_wdata[i])) |=> !clk_en[i]);
  end

endmodule

// File: tb/tb_txn_clk_gate_ctrl.sv
module tb_txn_clk_gate_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hint_we;
  logic [3:0] hint_wdata;
  logic [3:0] dom_idle;
  logic       low_power;
  logic [3:0] clk_en;
  logic [3:0] en_status;

  int n_vec  = 0;
  int n_fail = 0;

  logic [3:0] hint_m;
  logic [3:0] en_m;

  always #10 clk = ~clk;

  txn_clk_gate_ctrl #(.NUM_DOM(4)) dut (
    .clk(clk), .rst_n(rst_n), .hint_we(hint_we), .hint_wdata(hint_wdata),
    .dom_idle(dom_idle), .low_power(low_power),
    .clk_en(clk_en), .en_status(en_status)
  );

  function automatic logic [3:0] next_en(logic [3:0] en, logic [3:0] h,
                                         logic [3:0] idle, logic lp);
    if (lp) return 4'h0;
    return h | (en & ~idle);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hint_m <= 4'hF;
      en_m   <= 4'hF;
    end else begin
      hint_m <= hint_we ? hint_wdata : hint_m;
      en_m   <= next_en(en_m, hint_we ? hint_wdata : hint_m, dom_idle, low_power);
    end
  end

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_both(string req, logic [3:0] exp);
    check(req, clk_en, exp);
    check({req, "/R8"}, en_status, exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(logic we, logic [3:0] wd, logic [3:0] idle, logic lp);
    hint_we = we; hint_wdata = wd; dom_idle = idle; low_power = lp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 4'h0, 4'h0, 1'b0);
    repeat (3) @(negedge clk);
    check_both("R1", 4'hF);
    rst_n = 1'b1;
    step();
    check_both("R1", 4'hF);

    // R4: clear hints while all busy
    drive(1'b1, 4'h0, 4'h0, 1'b0);
    step();
    check_both("R4", 4'hF);
    drive(1'b0, 4'h0, 4'h0, 1'b0);
    step(); step();
    check_both("R4", 4'hF);
    // R2 / R4: only domain 2 reports idle
    drive(1'b0, 4'h0, 4'h4, 1'b0);
    step();
    check_both("R2", 4'hB);
    // R6: idle drops again, domain 2 stays off
    drive(1'b0, 4'h0, 4'h0, 1'b0);
    step(); step();
    check_both("R6", 4'hB);
    // R9: data without strobe is ignored
    drive(1'b0, 4'hF, 4'h0, 1'b0);
    step();
    check_both("R9", 4'hB);
    drive(1'b0, 4'h0, 4'hF, 1'b0);
    step();
    check_both("R9", 4'h0);
    // R3 / R2: single-bit enables
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 4'(1 << i), 4'hF, 1'b0);
      step();
      check_both("R3", 4'(1 << i));
    end
    drive(1'b1, 4'h5, 4'h0, 1'b0);
    step();
    check_both("R3", 4'hD);
    // R5: low power overrides, even with a write of ones
    drive(1'b1, 4'hF, 4'h0, 1'b1);
    step();
    check_both("R5", 4'h0);
    drive(1'b1, 4'h5, 4'h0, 1'b1);
    step();
    check_both("R5", 4'h0);
    // R7: exit low power, hint 0101 returns, others stay off though busy
    drive(1'b0, 4'h0, 4'h0, 1'b0);
    step();
    check_both("R7", 4'h5);

    // Random phase: R3 R4 R5 R6 R7 R9 against the bench model
    void'($urandom(32'h1234_5678));
    for (int n = 0; n < 4000; n++) begin
      drive(($urandom % 5) == 0, 4'($urandom), 4'($urandom), ($urandom % 9) == 0);
      step();
      check_both("R4", en_m);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule